// File: doc/BRIEF.md
# Two-Level Zero-Penalty Loop Sequencer

This block steers the fetch address of a packet-based processor so that counted loops repeat without a branch instruction and without a lost cycle. Two loop levels are kept, level 0 for the inner loop and level 1 for the outer loop. Each level holds a start address and a remaining-iteration count. A setup command writes both values for one level. The same values can also be read and written through a small control-register port.

Every packet arrives with its fall-through address and two end markers, one for each level. It may also carry a taken branch. One cycle later the block returns the address to fetch next. That address is the branch target, the start of a loop that still has iterations left, or the fall-through. Each pass through a loop end uses up one iteration. A body set up with count N therefore runs exactly N times. A packet that closes both levels serves the inner level first.

Top module: `hwloop_ctrl`

## Requirements
- R1: After a synchronous reset, next_valid, loop_back and cr_rdata are 0, and all four loop registers read back as 0.
- R2: A setup command loads setup_start and setup_count into the level named by setup_sel (0 selects level 0, 1 selects level 1). The new values are readable through the control-register port from the following cycle.
- R3: A setup command with count 0 stores a count of 1.
- R4: A valid packet with end0 set, no taken branch, and a level-0 count above 1 produces next_pc equal to start0 and loop_back = 1 in the next cycle, and decrements count0. next_valid is raised in that same cycle, so no cycle is lost.
- R5: At an end marker whose count is 1 or 0, that count becomes 0 and next_pc is the fall-through address. A body set up with count N therefore executes exactly N times.
- R6: Level 1 follows the same rules through end1, start1 and count1, independently of level 0. With an outer loop of count A around an inner loop of count B, the inner end packet runs A*B times.
- R7: When one packet carries both end0 and end1, level 0 is evaluated first. Level 1 is examined, and its count changed, only when level 0 falls through.
- R8: A taken branch in a packet makes next_pc equal to pkt_br_target with loop_back = 0, and neither count changes.
- R9: next_valid equals pkt_valid of the previous cycle. A valid packet with no end marker and no branch gives its fall-through address and leaves both counts unchanged.
- R10: The control-register port is addressed as follows: 0 = start0, 1 = count0, 2 = start1, 3 = count1. cr_we writes cr_wdata to the addressed register, and a count written this way is stored unmodified. cr_rdata shows, one cycle later, the value the addressed register held before that cycle's update.
- R11: In one cycle, a setup command overrides a control-register write to the same level, and a control-register count write overrides the decrement or clear caused by a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid | input | 1 | Loop setup command |
| setup_sel | input | 1 | Level targeted by setup (0 inner, 1 outer) |
| setup_start | input | AW | Loop start address |
| setup_count | input | CW | Iteration count |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_fallthru | input | AW | Sequential next address of the packet |
| pkt_end0 | input | 1 | Packet closes level 0 |
| pkt_end1 | input | 1 | Packet closes level 1 |
| pkt_br_taken | input | 1 | Packet contains a taken branch |
| pkt_br_target | input | AW | Branch target address |
| cr_we | input | 1 | Control-register write enable |
| cr_addr | input | 2 | Control-register select |
| cr_wdata | input | DW | Control-register write data |
| cr_rdata | output | DW | Registered read data |
| next_pc | output | AW | Next fetch address |
| next_valid | output | 1 | next_pc is meaningful |
| loop_back | output | 1 | next_pc is a loop start |

## Verification
A behavioural model is compared against the block on every clock. The stimulus covers a single loop of count 3, a nested outer/inner pair that is re-armed from the outer body, packets that close both levels while the inner count is above 1 and while it is exhausted, a branch colliding with an end marker, a zero setup count, and same-cycle collisions among setup, register writes and packet updates. The single loop and the nested pair separate an off-by-one in the iteration count from a fault in how the two levels interact. The dual-end packets expose a wrong evaluation order. The branch case separates correct priority from a decrement that leaks through.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  localparam int HWL_LEVELS = 2;

  typedef enum logic [1:0] {
    CR_START0 = 2'd0,
    CR_COUNT0 = 2'd1,
    CR_START1 = 2'd2,
    CR_COUNT1 = 2'd3
  } cr_sel_e;
endpackage

// File: rtl/hwl_loop_reg.sv
module hwl_loop_reg #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_start,
  input  logic [CW-1:0] set_count,
  input  logic          wr_start,
  input  logic          wr_count,
  input  logic [DW-1:0] wr_data,
  input  logic          step,
  output logic [AW-1:0] start_q,
  output logic [CW-1:0] count_q,
  output logic          again
);
  assign again = count_q > CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      count_q <= '0;
    end else if (set_en) begin
      start_q <= set_start;
      count_q <= (set_count == '0) ? CW'(1) : set_count;
    end else begin
      if (wr_start) start_q <= wr_data[AW-1:0];
      if (wr_count)  count_q <= wr_data[CW-1:0];
      else if (step) count_q <= again ? count_q - CW'(1) : '0;
    end
  end
endmodule

// File: rtl/hwl_pc_sel.sv
module hwl_pc_sel #(
  parameter int AW = 32
) (
  input  logic          pkt_valid,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  input  logic          end0,
  input  logic          end1,
  input  logic [AW-1:0] fallthru,
  input  logic [AW-1:0] start0,
  input  logic [AW-1:0] start1,
  input  logic          again0,
  input  logic          again1,
  output logic [AW-1:0] nxt,
  output logic          redirect,
  output logic [1:0]    step
);
  logic take0, take1;

  always_comb begin
    step[0]  = pkt_valid && !br_taken && end0;
    take0    = step[0] && again0;
    step[1]  = pkt_valid && !br_taken && end1 && !take0;
    take1    = step[1] && again1;
    redirect = take0 || take1;
    if (br_taken)   nxt = br_target;
    else if (take0) nxt = start0;
    else if (take1) nxt = start1;
    else            nxt = fallthru;
  end
endmodule

// File: rtl/hwl_cr_mux.sv
module hwl_cr_mux #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int DW = 32
) (
  input  logic [1:0]    addr,
  input  logic [AW-1:0] start_q [hwl_pkg::HWL_LEVELS],
  input  logic [CW-1:0] count_q [hwl_pkg::HWL_LEVELS],
  output logic [DW-1:0] rd
);
  import hwl_pkg::*;
  always_comb begin
    unique case (cr_sel_e'(addr))
      CR_START0: rd = DW'(start_q[0]);
      CR_COUNT0: rd = DW'(count_q[0]);
      CR_START1: rd = DW'(start_q[1]);
      default:   rd = DW'(count_q[1]);
    endcase
  end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int DW = (AW > CW) ? AW : CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          setup_valid,
  input  logic          setup_sel,
  input  logic [AW-1:0] setup_start,
  input  logic [CW-1:0] setup_count,
  input  logic          pkt_valid,
  input  logic [AW-1:0] pkt_fallthru,
  input  logic          pkt_end0,
  input  logic          pkt_end1,
  input  logic          pkt_br_taken,
  input  logic [AW-1:0] pkt_br_target,
  input  logic          cr_we,
  input  logic [1:0]    cr_addr,
  input  logic [DW-1:0] cr_wdata,
  output logic [DW-1:0] cr_rdata,
  output logic [AW-1:0] next_pc,
  output logic          next_valid,
  output logic          loop_back
);
  import hwl_pkg::*;

  logic [AW-1:0] start_q [HWL_LEVELS];
  logic [CW-1:0] count_q [HWL_LEVELS];
  logic [HWL_LEVELS-1:0] again;
  logic [HWL_LEVELS-1:0] step;
  logic [AW-1:0] nxt;
  logic          redirect;
  logic [DW-1:0] rd;

  for (genvar i = 0; i < HWL_LEVELS; i++) begin : g_lvl
    hwl_loop_reg #(.AW(AW), .CW(CW), .DW(DW)) u_loop (
      .clk      (clk),
      .rst      (rst),
      .set_en   (setup_valid && (setup_sel == 1'(i))),
      .set_start(setup_start),
      .set_count(setup_count),
      .wr_start (cr_we && (cr_addr == 2'(2*i))),
      .wr_count (cr_we && (cr_addr == 2'(2*i+1))),
      .wr_data  (cr_wdata),
      .step     (step[i]),
      .start_q  (start_q[i]),
      .count_q  (count_q[i]),
      .again    (again[i])
    );
  end

  hwl_pc_sel #(.AW(AW)) u_sel (
    .pkt_valid(pkt_valid),
    .br_taken (pkt_br_taken),
    .br_target(pkt_br_target),
    .end0     (pkt_end0),
    .end1     (pkt_end1),
    .fallthru (pkt_fallthru),
    .start0   (start_q[0]),
    .start1   (start_q[1]),
    .again0   (again[0]),
    .again1   (again[1]),
    .nxt      (nxt),
    .redirect (redirect),
    .step     (step)
  );

  hwl_cr_mux #(.AW(AW), .CW(CW), .DW(DW)) u_rd (
    .addr   (cr_addr),
    .start_q(start_q),
    .count_q(count_q),
    .rd     (rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc    <= '0;
      next_valid <= 1'b0;
      loop_back  <= 1'b0;
      cr_rdata   <= '0;
    end else begin
      next_pc    <= nxt;
      next_valid <= pkt_valid;
      loop_back  <= redirect;
      cr_rdata   <= rd;
    end
  end
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          setup_valid,
  input logic          setup_sel,
  input logic [CW-1:0] setup_count,
  input logic          pkt_valid,
  input logic          pkt_end0,
  input logic          pkt_end1,
  input logic          pkt_br_taken,
  input logic [AW-1:0] pkt_br_target,
  input logic          cr_we,
  input logic [AW-1:0] next_pc,
  input logic          next_valid,
  input logic          loop_back,
  input logic [AW-1:0] start_q [2],
  input logic [CW-1:0] count_q [2]
);
  // R8
  br_target_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_br_taken |=> next_pc == $past(pkt_br_target) && !loop_back);
  // R8
  br_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_br_taken && !setup_valid && !cr_we
    |=> count_q[0] == $past(count_q[0]) && count_q[1] == $past(count_q[1]));
  // R4
  back0_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_br_taken && pkt_end0 && count_q[0] > CW'(1) && !setup_valid && !cr_we
    |=> next_pc == $past(start_q[0]) && loop_back && next_valid
        && count_q[0] == $past(count_q[0]) - CW'(1));
  // R7
  inner_first_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_br_taken && pkt_end0 && pkt_end1 && count_q[0] > CW'(1)
      && !setup_valid && !cr_we
    |=> count_q[1] == $past(count_q[1]));
  // R3
  zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    setup_valid && !setup_sel && setup_count == '0 |=> count_q[0] == CW'(1));
  // R9
  valid_hi_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> next_valid);
  // R9
  valid_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |=> !next_valid && !loop_back);
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .setup_valid(setup_valid), .setup_sel(setup_sel),
  .setup_count(setup_count), .pkt_valid(pkt_valid), .pkt_end0(pkt_end0),
  .pkt_end1(pkt_end1), .pkt_br_taken(pkt_br_taken), .pkt_br_target(pkt_br_target),
  .cr_we(cr_we), .next_pc(next_pc), .next_valid(next_valid), .loop_back(loop_back),
  .start_q(start_q), .count_q(count_q)
);

// File: tb/hwloop_ctrl_test.sv
module hwloop_ctrl_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        setup_valid = 0, setup_sel = 0;
  logic [31:0] setup_start = 0, setup_count = 0;
  logic        pkt_valid = 0, pkt_end0 = 0, pkt_end1 = 0, pkt_br_taken = 0;
  logic [31:0] pkt_fallthru = 0, pkt_br_target = 0;
  logic        cr_we = 0;
  logic [1:0]  cr_addr = 0;
  logic [31:0] cr_wdata = 0;
  logic [31:0] cr_rdata, next_pc;
  logic        next_valid, loop_back;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hwloop_ctrl uut (.*);

  // behavioural reference
  logic [31:0] m_s [2];
  logic [31:0] m_c [2];
  logic [31:0] e_pc, e_rd;
  logic        e_v, e_lb;
  string       e_tag;

  always @(posedge clk) begin
    if (rst) begin
      m_s = '{0, 0}; m_c = '{0, 0};
      e_pc = 0; e_rd = 0; e_v = 0; e_lb = 0; e_tag = "R1";
    end else begin
      bit fin;
      logic [31:0] regs [4];
      regs = '{m_s[0], m_c[0], m_s[1], m_c[1]};
      e_rd = regs[cr_addr];
      e_v = pkt_valid; e_lb = 0; e_tag = "R9"; e_pc = pkt_fallthru;
      if (pkt_valid) begin
        if (pkt_br_taken) begin
          e_pc = pkt_br_target; e_tag = "R8";
        end else begin
          fin = 0;
          if (pkt_end0) begin
            if (m_c[0] > 1) begin
              m_c[0] -= 1; e_pc = m_s[0]; e_lb = 1; fin = 1; e_tag = "R4";
            end else begin
              m_c[0] = 0; e_tag = "R5";
            end
          end
          if (!fin && pkt_end1) begin
            if (m_c[1] > 1) begin
              m_c[1] -= 1; e_pc = m_s[1]; e_lb = 1; e_tag = "R6";
            end else begin
              m_c[1] = 0; e_tag = "R6";
            end
          end
        end
      end
      if (cr_we) begin
        if (cr_addr[0]) m_c[cr_addr[1]] = cr_wdata;
        else            m_s[cr_addr[1]] = cr_wdata;
      end
      if (setup_valid) begin
        m_s[setup_sel] = setup_start;
        m_c[setup_sel] = (setup_count == 0) ? 1 : setup_count;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk({e_tag, " next_valid"}, 32'(next_valid), 32'(e_v));
    chk({e_tag, " loop_back"}, 32'(loop_back), 32'(e_lb));
    if (e_v) chk({e_tag, " next_pc"}, next_pc, e_pc);
    chk("R10 cr_rdata", cr_rdata, e_rd);
  endtask

  task automatic quiet();
    setup_valid = 0; pkt_valid = 0; pkt_end0 = 0; pkt_end1 = 0;
    pkt_br_taken = 0; cr_we = 0;
  endtask

  task automatic do_setup(bit sel, logic [31:0] st, logic [31:0] cnt);
    quiet(); setup_valid = 1; setup_sel = sel; setup_start = st; setup_count = cnt;
    cyc(); quiet();
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] v);
    quiet(); cr_addr = a; cyc(); v = cr_rdata;
  endtask

  task automatic pkt(logic [31:0] fall, bit e0, bit e1, bit br, logic [31:0] tgt);
    quiet(); pkt_valid = 1; pkt_fallthru = fall; pkt_end0 = e0; pkt_end1 = e1;
    pkt_br_taken = br; pkt_br_target = tgt; cyc(); quiet();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, pc;
    int n_a, n_b;
    quiet();
    cyc(); cyc();
    chk("R1 next_valid", 32'(next_valid), 0);
    chk("R1 cr_rdata", cr_rdata, 0);
    rst = 0;
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v); chk("R1 reg", v, 0);
    end

    // R2 setup and readback
    do_setup(1, 32'h0000_4000, 32'd9);
    rd_reg(2, v); chk("R2 start1", v, 32'h4000);
    rd_reg(3, v); chk("R2 count1", v, 9);

    // R3 zero count
    do_setup(1, 32'h0000_0500, 0);
    rd_reg(3, v); chk("R3 count1", v, 1);
    pkt(32'h504, 0, 1, 0, 0);
    chk("R5 fall with count 1", next_pc, 32'h504);
    rd_reg(3, v); chk("R5 count cleared", v, 0);

    // R5 single loop of count 3, body 0x300..0x308
    do_setup(0, 32'h300, 3);
    pc = 32'h300; n_a = 0;
    for (int k = 0; k < 40 && pc != 32'h30C; k++) begin
      if (pc == 32'h308) n_a++;
      pkt(pc + 4, pc == 32'h308, 0, 0, 0);
      pc = next_pc;
    end
    chk("R5 body runs three times", 32'(n_a), 3);

    // R6 nested: outer count 3 at 0x100..0x10C, inner count 2 at 0x104..0x108
    do_setup(1, 32'h100, 3);
    pc = 32'h100; n_a = 0; n_b = 0;
    for (int k = 0; k < 100 && pc != 32'h110; k++) begin
      if (pc == 32'h108) n_a++;
      if (pc == 32'h10C) n_b++;
      quiet();
      pkt_valid = 1; pkt_fallthru = pc + 4;
      pkt_end0 = (pc == 32'h108); pkt_end1 = (pc == 32'h10C);
      if (pc == 32'h100) begin
        setup_valid = 1; setup_sel = 0; setup_start = 32'h104; setup_count = 2;
      end
      cyc(); quiet();
      pc = next_pc;
    end
    chk("R6 inner end count", 32'(n_a), 6);
    chk("R6 outer end count", 32'(n_b), 3);

    // R7 packet closing both levels
    do_setup(0, 32'h200, 2);
    do_setup(1, 32'h1F0, 5);
    pkt(32'h204, 1, 1, 0, 0);
    chk("R7 inner served first", next_pc, 32'h200);
    rd_reg(3, v); chk("R7 outer untouched", v, 5);
    pkt(32'h204, 1, 1, 0, 0);
    chk("R7 outer after inner exhausted", next_pc, 32'h1F0);
    rd_reg(3, v); chk("R7 outer decremented", v, 4);

    // R8 branch priority
    do_setup(0, 32'h600, 3);
    pkt(32'h60C, 1, 0, 1, 32'h900);
    chk("R8 branch target", next_pc, 32'h900);
    rd_reg(1, v); chk("R8 count kept", v, 3);

    // R9 plain packet
    pkt(32'h700, 0, 0, 0, 0);
    chk("R9 fallthrough", next_pc, 32'h700);
    rd_reg(1, v); chk("R9 count kept", v, 3);

    // R10 raw count write
    quiet(); cr_we = 1; cr_addr = 1; cr_wdata = 0; cyc(); quiet();
    rd_reg(1, v); chk("R10 raw zero", v, 0);
    quiet(); cr_we = 1; cr_addr = 0; cr_wdata = 32'hABC; cyc(); quiet();
    rd_reg(0, v); chk("R10 start0 write", v, 32'hABC);

    // R11 priorities
    quiet(); setup_valid = 1; setup_sel = 0; setup_start = 32'h800; setup_count = 7;
    cr_we = 1; cr_addr = 1; cr_wdata = 9; cyc(); quiet();
    rd_reg(1, v); chk("R11 setup beats write", v, 7);
    quiet(); pkt_valid = 1; pkt_fallthru = 32'h810; pkt_end0 = 1;
    cr_we = 1; cr_addr = 1; cr_wdata = 4; cyc(); quiet();
    chk("R11 loop still taken", next_pc, 32'h800);
    rd_reg(1, v); chk("R11 write beats decrement", v, 4);

    cyc();
    done = 1;
    finish_run();
  end
endmodule